// File: doc/BRIEF.md
# SPI Master Transfer Timing Engine

This block runs one 8-bit SPI transfer at a time as the bus master. A start strobe with a parallel transmit word begins a transfer. The engine pulls its chip select low and waits a lead interval. It then produces sixteen serial clock edges and shifts the word out most significant bit first, while it collects the incoming serial bits into a receive word. After a closing half period it raises chip select again, pulses `done` and holds `busy` through an idle gap before it will accept the next start.

The serial clock comes from the system clock through a programmable half-period divider. A divider value of zero stops all progress. Clock polarity selects the rest level of SCK. Clock phase selects whether data is launched or captured on the leading edge. Each transfer carries two command bits. One gates a programmable lead delay, counted in system clocks from chip-select assertion to the first SCK edge. The other gates a programmable trailing gap after chip-select negation. When a command bit is clear, or its count is zero, the default applies: half an SCK period for the lead, and one system clock for the gap.

The transmit word, the phase and the trailing-gap settings are captured when a start is accepted. The divider value is used live and must be held steady during a transfer, except that zero may be written to pause it.

Top module: `spi_xfer_master`

## Requirements
- R1: With a divider value B in 2..255, consecutive SCK edges of a transfer are exactly B system clocks apart, so SCK runs at the system clock divided by 2·B, and every transfer makes exactly 16 SCK edges.
- R2: With a divider value of 0, a start is ignored: `busy` stays low, `cs_n` stays high and SCK holds its idle level. If the divider is set to 0 during a transfer, SCK, `cs_n` and all internal timing freeze until the value is nonzero again, and the transfer then completes with correct data.
- R3: Outside a transfer SCK rests at the `cpol` level, following it one clock later. The first (leading) edge of a transfer moves SCK away from `cpol`, and edges alternate from there.
- R4: With `cpha`=0 the first MOSI bit is valid from chip-select assertion, both sides capture on odd (leading) edges and MOSI changes on even (trailing) edges. With `cpha`=1 MOSI changes on leading edges and both sides capture on trailing edges.
- R5: The transmit word is sent most significant bit first. MISO bits are assembled most significant bit first, and the result appears on `rx_word`.
- R6: When `lead_en`=1 and `lead_cnt` is nonzero, the first SCK edge comes exactly `lead_cnt` system clocks after `cs_n` falls.
- R7: When `lead_en`=0 or `lead_cnt`=0, the first SCK edge comes B system clocks (half an SCK period) after `cs_n` falls.
- R8: `cs_n` stays low through the whole transfer and rises B system clocks after the 16th SCK edge.
- R9: `done` is high for exactly one clock, in the first cycle with `cs_n` high after the transfer, and `rx_word` holds the received byte in that cycle.
- R10: When `trail_en`=1 and `trail_cnt` is nonzero, `busy` falls exactly `trail_cnt` system clocks after `cs_n` rises. Otherwise it falls one system clock after.
- R11: An accepted start makes `busy` high and `cs_n` low in the next cycle. A start while `busy` is high is ignored: the running transfer keeps its data and timing and no extra transfer follows.
- R12: During reset `cs_n`=1, `busy`=0, `done`=0, `rx_word`=0 and SCK=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | 8 | SCK half period in system clocks; 0 stops the engine |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| lead_en | input | 1 | Command bit enabling the programmed lead delay |
| lead_cnt | input | 7 | Lead delay in system clocks (1..127) |
| trail_en | input | 1 | Command bit enabling the programmed trailing gap |
| trail_cnt | input | 8 | Trailing gap in system clocks |
| start | input | 1 | One-cycle request to begin a transfer |
| tx_word | input | 8 | Word to send, captured on an accepted start |
| rx_word | output | 8 | Last received word |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | High from an accepted start until the trailing gap ends |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Every output is registered, so counts start at the clock edge that accepts the start, which is the cycle in which `cs_n` is seen low. From there the first SCK edge is due L clocks later (L is the lead count or B), each further edge B clocks after the previous one, and the `cs_n` rise and `done` pulse L+16·B clocks after `cs_n` fell. `busy` falls G clocks after `cs_n` rises, where G is the gap count or 1. The bench samples on the falling clock edge and logs the cycle number of every edge on `cs_n`, SCK, `done` and `busy`. It compares the differences between those cycle numbers against values computed from the configuration of each sweep point. A bench slave launches MISO and captures MOSI on the edges that R4 assigns to each phase.

// File: rtl/spi_xfer_pkg.sv
// Package: shared types and helpers for the SPI transfer engine.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package spi_xfer_pkg;

    // Sequencer phases of one transfer.
    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_LEAD  = 2'd1,
        XS_SHIFT = 2'd2,
        XS_GAP   = 2'd3
    } xfer_state_e;

    // Largest of three widths, used to size the shared timer.
    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/spi_phase_timer.sv
// Module: loadable down counter that times every phase of a transfer
// (lead delay, SCK half periods, closing hold, trailing gap).
// Assumes: load has priority; counting pauses while run is low and
// stops at zero, where expired is reported.
module spi_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down towards zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/spi_shift_unit.sv
// Module: transmit and receive shift registers, most significant bit first.
// Assumes: the sequencer supplies one-cycle launch and capture strobes
// that never coincide with load.
module spi_shift_unit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              launch,
    input  logic              capture,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_shift
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;

    // Load the word, then advance the outgoing bit on each launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= tx_word;
        end else if (launch) begin
            tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    // Clear on load, then append the incoming bit on each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load) begin
            rx_q <= '0;
        end else if (capture) begin
            rx_q <= {rx_q[DATA_W-2:0], miso};
        end
    end

    assign mosi     = tx_q[DATA_W-1];
    assign rx_shift = rx_q;

endmodule

// File: rtl/spi_seq_ctrl.sv
// Module: transfer sequencer. Owns chip select, SCK, edge numbering and
// the selection of each phase length for the shared timer.
// Assumes: baud_div is held steady during a transfer apart from pausing
// with zero; phase and trailing-gap settings are captured at start.
module spi_seq_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int BAUD_W  = 8,
    parameter int LEAD_W  = 7,
    parameter int TRAIL_W = 8,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BAUD_W-1:0]  baud_div,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               lead_en,
    input  logic [LEAD_W-1:0]  lead_cnt,
    input  logic               trail_en,
    input  logic [TRAIL_W-1:0] trail_cnt,
    input  logic               tmr_expired,
    output logic               tmr_run,
    output logic               tmr_load,
    output logic [CNT_W-1:0]   tmr_val,
    output logic               accept,
    output logic               launch,
    output logic               capture,
    output logic               finish,
    output logic               sck,
    output logic               cs_n,
    output logic               busy,
    output logic               done
);

    localparam int EDGE_TOTAL = 2 * DATA_W;
    localparam int EDGE_W     = $clog2(EDGE_TOTAL + 1);

    xfer_state_e        state_q;
    logic [EDGE_W-1:0]  edge_q;
    logic               sck_q;
    logic               cs_n_q;
    logic               done_q;
    logic               cpha_q;
    logic               trail_en_q;
    logic [TRAIL_W-1:0] trail_cnt_q;

    logic               tick;
    logic               all_edges;
    logic               edge_evt;
    logic [EDGE_W-1:0]  edge_num;
    logic               leading;
    logic               first_edge;
    logic               last_edge;
    logic [CNT_W-1:0]   half_len;
    logic [CNT_W-1:0]   lead_len;
    logic [CNT_W-1:0]   gap_len;

    // Timer runs only with a nonzero divider; a tick ends the current phase.
    assign tmr_run   = (baud_div != '0);
    assign tick      = tmr_run && tmr_expired;
    assign accept    = (state_q == XS_IDLE) && start && tmr_run;
    assign all_edges = (edge_q == EDGE_W'(EDGE_TOTAL));
    assign finish    = tick && (state_q == XS_SHIFT) && all_edges;

    // Edge bookkeeping: number of the SCK edge made at this tick.
    assign edge_evt   = tick && ((state_q == XS_LEAD) ||
                                 ((state_q == XS_SHIFT) && !all_edges));
    assign first_edge = (state_q == XS_LEAD);
    assign edge_num   = first_edge ? EDGE_W'(1) : (edge_q + EDGE_W'(1));
    assign leading    = edge_num[0];
    assign last_edge  = (edge_num == EDGE_W'(EDGE_TOTAL));

    // Phase decides which edges move MOSI and which sample MISO.
    assign launch  = edge_evt && (cpha_q ? (leading && !first_edge)
                                         : (!leading && !last_edge));
    assign capture = edge_evt && (cpha_q ? !leading : leading);

    // Phase lengths with their defaults when the command bit is off.
    assign half_len = CNT_W'(baud_div);
    assign lead_len = (lead_en && (lead_cnt != '0)) ? CNT_W'(lead_cnt) : half_len;
    assign gap_len  = (trail_en_q && (trail_cnt_q != '0)) ? CNT_W'(trail_cnt_q)
                                                          : CNT_W'(1);

    // Timer reload at each phase boundary, minus one for the reload cycle.
    assign tmr_load = accept || edge_evt || finish;
    always_comb begin
        if (accept) begin
            tmr_val = lead_len - CNT_W'(1);
        end else if (finish) begin
            tmr_val = gap_len - CNT_W'(1);
        end else begin
            tmr_val = half_len - CNT_W'(1);
        end
    end

    // Capture the per-transfer command bits at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpha_q      <= 1'b0;
            trail_en_q  <= 1'b0;
            trail_cnt_q <= '0;
        end else if (accept) begin
            cpha_q      <= cpha;
            trail_en_q  <= trail_en;
            trail_cnt_q <= trail_cnt;
        end
    end

    // Main sequencer: idle, lead, sixteen edges plus hold, trailing gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            edge_q  <= '0;
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
        end else begin
            unique case (state_q)
                XS_IDLE: begin
                    sck_q <= cpol;
                    if (accept) begin
                        state_q <= XS_LEAD;
                        cs_n_q  <= 1'b0;
                        edge_q  <= '0;
                    end
                end
                XS_LEAD: begin
                    if (tick) begin
                        sck_q   <= ~sck_q;
                        edge_q  <= EDGE_W'(1);
                        state_q <= XS_SHIFT;
                    end
                end
                XS_SHIFT: begin
                    if (tick) begin
                        if (all_edges) begin
                            cs_n_q  <= 1'b1;
                            state_q <= XS_GAP;
                        end else begin
                            sck_q  <= ~sck_q;
                            edge_q <= edge_q + EDGE_W'(1);
                        end
                    end
                end
                XS_GAP: begin
                    if (tick) begin
                        state_q <= XS_IDLE;
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    // One-cycle completion pulse aligned with chip-select negation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
        end
    end

    assign sck  = sck_q;
    assign cs_n = cs_n_q;
    assign busy = (state_q != XS_IDLE);
    assign done = done_q;

endmodule

// File: rtl/spi_xfer_master.sv
// Module: top of the SPI master transfer engine. Wires the sequencer,
// the shared phase timer and the shift unit, and holds the receive word.
// Assumes: a single slave on one chip select, transfers of DATA_W bits.
module spi_xfer_master #(
    parameter int DATA_W  = 8,
    parameter int BAUD_W  = 8,
    parameter int LEAD_W  = 7,
    parameter int TRAIL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BAUD_W-1:0]  baud_div,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               lead_en,
    input  logic [LEAD_W-1:0]  lead_cnt,
    input  logic               trail_en,
    input  logic [TRAIL_W-1:0] trail_cnt,
    input  logic               start,
    input  logic [DATA_W-1:0]  tx_word,
    output logic [DATA_W-1:0]  rx_word,
    output logic               done,
    output logic               busy,
    output logic               sck,
    output logic               mosi,
    input  logic               miso,
    output logic               cs_n
);

    localparam int CNT_W = spi_xfer_pkg::max3(BAUD_W, LEAD_W, TRAIL_W);

    logic              tmr_run;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              accept;
    logic              launch;
    logic              capture;
    logic              finish;
    logic [DATA_W-1:0] rx_shift;
    logic [DATA_W-1:0] rx_q;

    spi_seq_ctrl #(
        .DATA_W  (DATA_W),
        .BAUD_W  (BAUD_W),
        .LEAD_W  (LEAD_W),
        .TRAIL_W (TRAIL_W),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .baud_div    (baud_div),
        .cpol        (cpol),
        .cpha        (cpha),
        .lead_en     (lead_en),
        .lead_cnt    (lead_cnt),
        .trail_en    (trail_en),
        .trail_cnt   (trail_cnt),
        .tmr_expired (tmr_expired),
        .tmr_run     (tmr_run),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .launch      (launch),
        .capture     (capture),
        .finish      (finish),
        .sck         (sck),
        .cs_n        (cs_n),
        .busy        (busy),
        .done        (done)
    );

    spi_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_run),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    spi_shift_unit #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .tx_word  (tx_word),
        .launch   (launch),
        .capture  (capture),
        .miso     (miso),
        .mosi     (mosi),
        .rx_shift (rx_shift)
    );

    // Publish the assembled word at the end of the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (finish) begin
            rx_q <= rx_shift;
        end
    end

    assign rx_word = rx_q;

endmodule

// File: rtl/spi_xfer_master_chk.sv
// Module: protocol checker for spi_xfer_master, attached with bind.
// Assumes: observes top-level ports only.
module spi_xfer_master_chk #(
    parameter int BAUD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [BAUD_W-1:0] baud_div,
    input logic              cpol,
    input logic              busy,
    input logic              done,
    input logic              cs_n,
    input logic              sck
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9

    AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n)));  // R9

    AST_CS_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);  // R11

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (baud_div != '0)) |=> (busy && !cs_n));  // R11

    AST_BAUD_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (baud_div == '0)) |=> !busy);  // R2

    AST_BAUD_ZERO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(baud_div == '0) && $past(busy)) |-> $stable(sck));  // R2

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!busy) |-> (sck == $past(cpol)));  // R3

endmodule

bind spi_xfer_master spi_xfer_master_chk #(.BAUD_W(BAUD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .baud_div (baud_div),
    .cpol     (cpol),
    .busy     (busy),
    .done     (done),
    .cs_n     (cs_n),
    .sck      (sck)
);

// File: tb/spi_xfer_master_bench.sv
// Bench: sweeps mode, divider, lead and gap settings; timing and data
// expectations are computed from the requirements per sweep point.
module spi_xfer_master_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] baud_div = 8'd2;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       lead_en = 1'b0;
    logic [6:0] lead_cnt = '0;
    logic       trail_en = 1'b0;
    logic [7:0] trail_cnt = '0;
    logic       start = 1'b0;
    logic [7:0] tx_word = '0;
    logic [7:0] rx_word;
    logic       done;
    logic       busy;
    logic       sck;
    logic       mosi;
    logic       miso;
    logic       cs_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Monitor state (written only by the monitor process)
    int cs_falls = 0, cs_fall_cyc = 0, cs_rise_cyc = 0;
    int edges = 0, first_sck_cyc = 0, last_edge_cyc = 0;
    int interval_bad = 0, pol_bad = 0;
    int done_cnt = 0, done_cyc = 0, busy_fall_cyc = 0;
    logic [7:0] rx_at_done = '0, slv_rx = '0;
    logic prev_cs = 1'b1, prev_sck = 1'b0, prev_busy = 1'b0;

    // Settings of the running transfer (written only by the stimulus)
    logic [7:0] pat = '0;
    logic       m_cpol = 1'b0, m_cpha = 1'b0;
    int         exp_b = 2;

    spi_xfer_master u_spi_xfer_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_div  (baud_div),
        .cpol      (cpol),
        .cpha      (cpha),
        .lead_en   (lead_en),
        .lead_cnt  (lead_cnt),
        .trail_en  (trail_en),
        .trail_cnt (trail_cnt),
        .start     (start),
        .tx_word   (tx_word),
        .rx_word   (rx_word),
        .done      (done),
        .busy      (busy),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .cs_n      (cs_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Slave model and event log, sampled away from the active edge.
    always @(negedge clk) begin
        if (cs_n !== 1'b0) miso = pat[7];
        if (rst_n) begin
            if (prev_cs && (cs_n === 1'b0)) begin
                cs_falls++;
                cs_fall_cyc = cyc;
                edges = 0; interval_bad = 0; pol_bad = 0; slv_rx = '0;
            end
            if (!prev_cs && (cs_n === 1'b1)) cs_rise_cyc = cyc;
            if ((sck !== prev_sck) && (cs_n === 1'b0)) begin
                edges++;
                if (edges == 1) first_sck_cyc = cyc;
                else if (cyc - last_edge_cyc != exp_b) interval_bad++;
                last_edge_cyc = cyc;
                if (sck !== ((edges % 2 == 1) ? ~m_cpol : m_cpol)) pol_bad++;
                // Capture edges: odd for phase 0, even for phase 1
                if ((edges % 2 == 1) != m_cpha) slv_rx = {slv_rx[6:0], mosi};
                // Launch edges: the opposite kind
                if (!m_cpha && (edges % 2 == 0) && (edges / 2 <= 7))
                    miso = pat[7 - edges / 2];
                if (m_cpha && (edges % 2 == 1))
                    miso = pat[7 - (edges - 1) / 2];
            end
            if (done === 1'b1) begin
                done_cnt++;
                done_cyc = cyc;
                rx_at_done = rx_word;
            end
            if (prev_busy && (busy === 1'b0)) busy_fall_cyc = cyc;
        end
        prev_cs   = (cs_n !== 1'b0);
        prev_sck  = sck;
        prev_busy = (busy === 1'b1);
    end

    // One transfer; mode 0 plain, 1 divider paused mid-way, 2 start while busy.
    task automatic run_xfer(input int b, input bit pol, input bit pha,
                            input bit len, input int lcnt,
                            input bit ten, input int tcnt,
                            input logic [7:0] tx, input logic [7:0] pt,
                            input int mode);
        int exp_l, exp_g, t_start, base_falls, base_done, guard;
        logic s_hold;
        exp_l = (len && lcnt != 0) ? lcnt : b;
        exp_g = (ten && tcnt != 0) ? tcnt : 1;
        @(negedge clk);
        baud_div = 8'(b); cpol = pol; cpha = pha;
        lead_en = len; lead_cnt = 7'(lcnt);
        trail_en = ten; trail_cnt = 8'(tcnt);
        tx_word = tx; pat = pt; m_cpol = pol; m_cpha = pha; exp_b = b;
        repeat (3) @(negedge clk);
        expect_eq("R3 idle sck level", int'(sck), int'(pol));
        base_falls = cs_falls; base_done = done_cnt;
        start = 1'b1; t_start = cyc;
        @(negedge clk);
        start = 1'b0;
        if (mode == 1) begin
            repeat (10) @(negedge clk);
            baud_div = 8'd0;
            @(negedge clk);
            s_hold = sck;
            repeat (30) @(negedge clk);
            expect_eq("R2 sck frozen", int'(sck), int'(s_hold));
            expect_eq("R2 cs held low", int'(cs_n), 0);
            baud_div = 8'(b);
        end
        if (mode == 2) begin
            repeat (15) @(negedge clk);
            start = 1'b1; tx_word = ~tx;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy === 1'b1 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (6) @(negedge clk);
        expect_eq("R11 cs falls next cycle", cs_fall_cyc - t_start, 1);
        expect_eq("R11 one transfer only", cs_falls - base_falls, 1);
        expect_eq("R1 edge count", edges, 16);
        expect_eq("R3 edge polarity errors", pol_bad, 0);
        expect_eq("R4 slave saw mosi", int'(slv_rx), int'(tx));
        expect_eq("R5 rx word", int'(rx_at_done), int'(pt));
        expect_eq("R9 done pulses", done_cnt - base_done, 1);
        expect_eq("R9 done at cs rise", done_cyc, cs_rise_cyc);
        expect_eq("R10 busy gap", busy_fall_cyc - cs_rise_cyc, exp_g);
        if (mode != 1) begin
            expect_eq("R1 edge spacing errors", interval_bad, 0);
            if (len && lcnt != 0)
                expect_eq("R6 programmed lead", first_sck_cyc - cs_fall_cyc, exp_l);
            else
                expect_eq("R7 default lead", first_sck_cyc - cs_fall_cyc, exp_l);
            expect_eq("R8 cs low span", cs_rise_cyc - cs_fall_cyc, exp_l + 16 * b);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stimulus
        int idx;
        int bvals[3];
        int lvals[3];
        bvals = '{2, 3, 5};
        lvals = '{0, 1, 9};
        idx = 0;
        repeat (4) @(negedge clk);
        // R12 reset state
        expect_eq("R12 cs_n in reset", int'(cs_n), 1);
        expect_eq("R12 busy in reset", int'(busy), 0);
        expect_eq("R12 done in reset", int'(done), 0);
        expect_eq("R12 rx_word in reset", int'(rx_word), 0);
        expect_eq("R12 sck in reset", int'(sck), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        expect_eq("R3 sck follows cpol", int'(sck), 1);
        // R2 start with divider zero is ignored
        baud_div = 8'd0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        expect_eq("R2 busy stays low", int'(busy), 0);
        expect_eq("R2 cs stays high", int'(cs_n), 1);
        expect_eq("R2 sck stays idle", int'(sck), 1);
        expect_eq("R2 no cs fall", cs_falls, 0);
        // Sweep of modes, dividers, lead and gap settings
        for (int ph = 0; ph < 2; ph++)
            for (int po = 0; po < 2; po++)
                for (int bi = 0; bi < 3; bi++)
                    for (int le = 0; le < 2; le++)
                        for (int li = 0; li < 3; li++)
                            for (int te = 0; te < 2; te++)
                                for (int ti = 0; ti < 2; ti++) begin
                                    run_xfer(bvals[bi], po[0], ph[0], le[0], lvals[li],
                                             te[0], ti * 4, 8'(idx * 29 + 7),
                                             8'((idx * 53) ^ 8'hA5), 0);
                                    idx++;
                                end
        // Boundary settings
        run_xfer(255, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0, 8'h80, 8'h01, 0);
        run_xfer(2, 1'b1, 1'b0, 1'b1, 127, 1'b1, 255, 8'hFF, 8'h00, 0);
        run_xfer(255, 1'b1, 1'b1, 1'b1, 127, 1'b1, 1, 8'h5A, 8'hC3, 0);
        run_xfer(2, 1'b0, 1'b0, 1'b1, 1, 1'b0, 200, 8'h01, 8'h80, 0);
        // Divider paused mid-transfer, then a start while busy
        run_xfer(3, 1'b0, 1'b1, 1'b1, 5, 1'b0, 0, 8'h3C, 8'h96, 1);
        run_xfer(4, 1'b1, 1'b0, 1'b0, 0, 1'b1, 6, 8'hA7, 8'h4E, 2);
        run_xfer(2, 1'b0, 1'b1, 1'b1, 3, 1'b1, 3, 8'h12, 8'hED, 2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule